// File: doc/BRIEF.md
# LFSR-Counted Raster Timing Generator

This block produces the horizontal sync, vertical sync, display-enable, pixel-fetch window and frame-start strobe for a raster display. The pixel position in a line and the line position in a frame are each held in a 16-bit linear feedback shift register rather than a binary counter, so advancing a position needs no carry chain. Each boundary is found by equality between a position register and a programmed state. Software converts every boundary count N into the state that the register reaches after N steps from all-ones, and programs that state.

The pixel register advances once for each cycle with the pixel-clock enable high. The line register advances once each time the pixel register wraps. Two plain binary counters measure the offset of the current pixel and line inside the display window, and they limit the fetch window to the programmed active pixel and line counts. All comparator and count inputs are captured at the frame origin, so they can be rewritten at any time without tearing the current frame. A two-bit blank-mode input selects normal display, blanked picture with running syncs, or power-down.

Top module: `lfsr_raster_timer`

## Requirements
- R1: After reset both position registers hold 0xFFFF (pixel 0, line 0). With the enable low, hsync, disp_en, fetch_active and frame_start are low and vsync is high.
- R2: One step maps state s to {s[14:0], s[15]^s[4]^s[2]^s[1]}. The pixel position steps once per cycle with pix_en high and holds when it is low. When it equals h_last_st, the state after htotal−1 steps, it returns to 0xFFFF, so a line lasts htotal enabled cycles.
- R3: The line position steps only when the pixel position wraps. If the stepped value equals v_total_st, the state after vtotal steps, it returns to 0xFFFF instead, so a frame has vtotal lines.
- R4: hsync is high for pixel counts 1 through w, where h_sync_end_st is the state after w+1 steps.
- R5: vsync is high for lines 0 through w−1, where v_sync_end_st is the state after w steps (w at least 1).
- R6: In mode 0, disp_en is high when the pixel count lies in [hs, he) and the line count in [vs, ve). Here hs and he are the counts whose states are h_start_st and h_end_st, and the vertical pair works the same way with v_start_st and v_end_st. A window end equal to the total still closes at the wrap.
- R7: fetch_active is high when disp_en is high, the binary pixel offset from the window start is below act_pixels, and the binary line offset is below act_lines.
- R8: frame_start is high for exactly the cycle in which pix_en is high at pixel 0 of line 0.
- R9: blank_mode 2'b00 is normal display. 2'b01 forces disp_en and fetch_active low while both syncs keep running. 2'b10 and 2'b11 force hsync, vsync, disp_en and fetch_active low while positions keep advancing. frame_start is not affected by the mode.
- R10: Comparator and count inputs are used only as sampled while at pixel 0 of line 0. A change made mid-frame first applies to the frame after the next origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable; one pixel per high cycle |
| blank_mode | input | 2 | 00 display, 01 blank, 1x power-down |
| h_start_st | input | 16 | State for the first displayed pixel |
| h_end_st | input | 16 | State for the first pixel after the display window |
| h_sync_end_st | input | 16 | State ending hsync (width plus one) |
| h_last_st | input | 16 | State of the last pixel in a line (htotal−1) |
| v_start_st | input | 16 | State for the first displayed line |
| v_end_st | input | 16 | State for the first line after the display window |
| v_sync_end_st | input | 16 | State ending vsync (width) |
| v_total_st | input | 16 | State for vtotal; reaching it wraps the frame |
| act_pixels | input | ACT_W | Binary count of fetched pixels per line |
| act_lines | input | ACT_W | Binary count of fetched lines per frame |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | Display enable |
| fetch_active | output | 1 | Pixel-fetch window |
| frame_start | output | 1 | One-cycle strobe at the frame origin |

## Verification
The hardest case to reach is a comparator rewrite in the middle of a frame. The old timing must carry on through the rest of that frame, including the vertical wrap decided by the old total, and the new timing must begin exactly at the origin. The stimulus changes every comparator and count to a different geometry partway through a line of a frame whose enable has gaps. The scoreboard model keeps the old geometry until its own position reaches the origin. The bench also holds the enable low across line wraps and switches among all blank modes while positions keep moving, so the re-entry into display mode lands mid-frame.

// File: rtl/lfsr_raster_timer.sv
module lfsr_raster_timer #(
  parameter int ACT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic [1:0]       blank_mode,
  input  logic [15:0]      h_start_st,
  input  logic [15:0]      h_end_st,
  input  logic [15:0]      h_sync_end_st,
  input  logic [15:0]      h_last_st,
  input  logic [15:0]      v_start_st,
  input  logic [15:0]      v_end_st,
  input  logic [15:0]      v_sync_end_st,
  input  logic [15:0]      v_total_st,
  input  logic [ACT_W-1:0] act_pixels,
  input  logic [ACT_W-1:0] act_lines,
  output logic             hsync,
  output logic             vsync,
  output logic             disp_en,
  output logic             fetch_active,
  output logic             frame_start
);

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
  endfunction

  localparam logic [15:0] SEED  = 16'hFFFF;
  localparam logic [15:0] HS_ON = lfsr_next(SEED);
  localparam int          PW    = 8 * 16 + 2 * ACT_W;

  logic [15:0] hc, vc, hn, vstep, vn;
  logic [PW-1:0] cfg_in, cfg_sh, cfg;
  logic [15:0] c_hstart, c_hend, c_hsend, c_hlast;
  logic [15:0] c_vstart, c_vend, c_vsend, c_vtot;
  logic [ACT_W-1:0] c_actpx, c_actln, px, ln;
  logic h_act, hs_f, v_act, vs_f;
  logic origin, h_wrap, v_wrap, line_adv;

  assign cfg_in = {h_start_st, h_end_st, h_sync_end_st, h_last_st,
                   v_start_st, v_end_st, v_sync_end_st, v_total_st,
                   act_pixels, act_lines};
  assign origin = (hc == SEED) && (vc == SEED);
  assign cfg    = origin ? cfg_in : cfg_sh;
  assign {c_hstart, c_hend, c_hsend, c_hlast,
          c_vstart, c_vend, c_vsend, c_vtot, c_actpx, c_actln} = cfg;

  assign h_wrap   = (hc == c_hlast);
  assign hn       = h_wrap ? SEED : lfsr_next(hc);
  assign vstep    = lfsr_next(vc);
  assign v_wrap   = (vstep == c_vtot);
  assign vn       = v_wrap ? SEED : vstep;
  assign line_adv = pix_en && h_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc     <= SEED;
      vc     <= SEED;
      cfg_sh <= '0;
      h_act  <= 1'b0;
      hs_f   <= 1'b0;
      v_act  <= 1'b0;
      vs_f   <= 1'b1;
      px     <= '0;
      ln     <= '0;
    end else begin
      cfg_sh <= cfg;
      if (pix_en) begin
        hc <= hn;
        px <= h_act ? px + 1'b1 : '0;
        if (h_wrap) begin
          h_act <= (c_hstart == SEED);
          hs_f  <= 1'b0;
        end else begin
          if (hn == c_hstart)    h_act <= 1'b1;
          else if (hn == c_hend) h_act <= 1'b0;
          if (hn == HS_ON)        hs_f <= 1'b1;
          else if (hn == c_hsend) hs_f <= 1'b0;
        end
      end
      if (line_adv) begin
        vc <= vn;
        ln <= v_act ? ln + 1'b1 : '0;
        if (v_wrap) begin
          v_act <= (c_vstart == SEED);
          vs_f  <= 1'b1;
        end else begin
          if (vn == c_vstart)    v_act <= 1'b1;
          else if (vn == c_vend) v_act <= 1'b0;
          if (vn == c_vsend) vs_f <= 1'b0;
        end
      end
    end
  end

  assign hsync        = hs_f & ~blank_mode[1];
  assign vsync        = vs_f & ~blank_mode[1];
  assign disp_en      = (blank_mode == 2'b00) & h_act & v_act;
  assign fetch_active = disp_en & (px < c_actpx) & (ln < c_actln);
  assign frame_start  = origin & pix_en;

endmodule

module lfsr_raster_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_en,
  input logic [1:0]  blank_mode,
  input logic        hsync,
  input logic        vsync,
  input logic        disp_en,
  input logic        fetch_active,
  input logic        frame_start,
  input logic [15:0] hc,
  input logic [15:0] vc,
  input logic [15:0] c_hlast
);

  a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(hc) && $stable(vc)));

  a_r3_line_moves_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_en && hc == c_hlast) |=> $stable(vc));

  a_r7_fetch_inside_display: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_active |-> disp_en);

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r9_powerdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    blank_mode[1] |-> !(hsync || vsync || disp_en || fetch_active));

  a_r9_blank_no_display: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_mode != 2'b00) |-> !disp_en);

endmodule

bind lfsr_raster_timer lfsr_raster_timer_chk u_chk (.*);

// File: tb/test_lfsr_raster_timer.sv
module test_lfsr_raster_timer;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0;
  logic [1:0] blank_mode = 2'b00;
  logic [15:0] h_start_st, h_end_st, h_sync_end_st, h_last_st;
  logic [15:0] v_start_st, v_end_st, v_sync_end_st, v_total_st;
  logic [15:0] act_pixels, act_lines;
  logic hsync, vsync, disp_en, fetch_active, frame_start;

  always #(CLK_P / 2) clk = ~clk;

  lfsr_raster_timer i_lfsr_raster_timer (.*);

  typedef struct {
    logic [4:0] v;
    logic [1:0] mode;
    bit         reprog;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit reprog_phase = 0;

  int H, A, HSS, HSE, VT, VD, VSS, VSE, PX, LN;   // driven (pending)
  int cH, cA, cHSS, cHSE, cVT, cVD, cVSS, cVSE, cPX, cLN; // in use
  int hpos = 0, vpos = 0;

  function automatic logic [15:0] st_after(input int n);
    logic [15:0] s = 16'hFFFF;
    for (int i = 0; i < n; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  task automatic set_geom(input int h, a, hss, hse, vt, vd, vss, vse, p, l);
    H = h; A = a; HSS = hss; HSE = hse; VT = vt; VD = vd; VSS = vss; VSE = vse;
    PX = p; LN = l;
    h_start_st    = st_after(h - hss);
    h_end_st      = st_after(h - hss + a);
    h_sync_end_st = st_after(hse - hss + 1);
    h_last_st     = st_after(h - 1);
    v_start_st    = st_after(vt - vss);
    v_end_st      = st_after(vt - vss + vd);
    v_sync_end_st = st_after(vse - vss);
    v_total_st    = st_after(vt);
    act_pixels    = 16'(p);
    act_lines     = 16'(l);
  endtask

  task automatic step_cycle(input logic pe, input logic [1:0] mode);
    exp_t e;
    int hds, vds;
    logic on, pd, de;
    @(negedge clk);
    pix_en = pe;
    blank_mode = mode;
    if (hpos == 0 && vpos == 0) begin  // R10: geometry taken at the origin
      cH = H; cA = A; cHSS = HSS; cHSE = HSE; cVT = VT; cVD = VD;
      cVSS = VSS; cVSE = VSE; cPX = PX; cLN = LN;
    end
    on = (mode == 2'b00);
    pd = mode[1];
    hds = cH - cHSS;
    vds = cVT - cVSS;
    de = on && hpos >= hds && hpos < hds + cA && vpos >= vds && vpos < vds + cVD;
    e.v[4] = !pd && hpos >= 1 && hpos <= (cHSE - cHSS);
    e.v[3] = !pd && vpos < (cVSE - cVSS);
    e.v[2] = de;
    e.v[1] = de && (hpos - hds) < cPX && (vpos - vds) < cLN;
    e.v[0] = pe && hpos == 0 && vpos == 0;
    e.mode = mode;
    e.reprog = reprog_phase;
    q.push_back(e);
    if (pe) begin
      if (hpos == cH - 1) begin
        hpos = 0;
        vpos = (vpos + 1 == cVT) ? 0 : vpos + 1;
      end else hpos = hpos + 1;
    end
  endtask

  task automatic run(input int n, input int gap, input logic [1:0] mode);
    for (int i = 0; i < n; i++) step_cycle(!(gap > 0 && (i % gap) == gap - 1), mode);
  endtask

  always @(negedge clk) begin
    #(CLK_P / 4);
    while (q.size() > 0) begin
      exp_t e;
      logic [4:0] act;
      string tags [5];
      string pre;
      e = q.pop_front();
      act = {hsync, vsync, disp_en, fetch_active, frame_start};
      tags[4] = "R4 R2"; tags[3] = "R5 R3"; tags[2] = "R6";
      tags[1] = "R7";    tags[0] = "R8";
      pre = "";
      if (e.mode != 2'b00) pre = {pre, "R9 "};
      if (e.reprog) pre = {pre, "R10 "};
      for (int b = 0; b < 5; b++) begin
        n_chk++;
        if (act[b] !== e.v[b]) begin
          n_fail++;
          $display("FAIL %s%s at h=%0d v=%0d: actual %b expected %b",
                   pre, tags[b], hpos, vpos, act[b], e.v[b]);
        end
      end
    end
  end

  bit done = 0;
  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    set_geom(24, 12, 16, 19, 10, 5, 7, 9, 10, 4);
    cH = H; cA = A; cHSS = HSS; cHSE = HSE; cVT = VT; cVD = VD;
    cVSS = VSS; cVSE = VSE; cPX = PX; cLN = LN;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_P / 4);
    n_chk++;  // R1: reset state at the origin with the enable low
    if ({hsync, vsync, disp_en, fetch_active, frame_start} !== 5'b01000) begin
      n_fail++;
      $display("FAIL R1 reset outputs: actual %b expected 01000",
               {hsync, vsync, disp_en, fetch_active, frame_start});
    end
    run(4, 0, 2'b00);
    for (int i = 0; i < 4; i++) step_cycle(1'b0, 2'b00); // R2: holds without enable
    run(480, 0, 2'b00);        // two frames, continuous enable
    run(360, 3, 2'b00);        // gaps in the enable, some across wraps
    run(250, 0, 2'b01);        // R9 blank
    run(250, 0, 2'b10);        // R9 power-down
    run(70, 4, 2'b11);
    run(200, 0, 2'b00);
    while (!(vpos == 2 && hpos == 5)) step_cycle(1'b1, 2'b00);
    reprog_phase = 1;          // R10: rewrite mid-frame
    set_geom(20, 10, 14, 16, 8, 4, 5, 6, 7, 3);
    run(400, 5, 2'b00);
    run(330, 0, 2'b00);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule